// File: doc/BRIEF.md
# Iterative BCD Coefficient Multiplier

This block forms the product of two unsigned decimal coefficients, each held as sixteen packed BCD-8421 digits (four bits per digit, least significant digit in bits 3:0), using one decimal adder that is reused for the whole operation. A multiplication begins when `start_i` is sampled high while the block is idle. The block first fills a table with the multiples 1X to 9X of the multiplicand by repeated decimal addition (the multiple 0X is the constant zero), then walks the multiplier digits from the most significant down, each step shifting the running product one decimal place left and adding the multiple picked by the current digit.

Alongside the coefficient, the result sign is formed as the exclusive-or of the operand signs and the preliminary exponent as the two's complement sum of the operand exponents. The product is 32 digits wide, so no digit is ever dropped. Rounding, special values and any encoding conversion sit outside this block; there is no binary conversion anywhere in the datapath.

Top module: `bcd_coef_mul`

## Requirements
- R1: While reset is applied and after it is released, `busy_o` and `done_o` are 0 and `prod_o` is 0; an asserted reset aborts a running multiplication.
- R2: When `done_o` is high, `prod_o` holds the exact 32-digit packed BCD product of the `x_i` and `y_i` values captured at the accepted start, every digit in the range 0 to 9.
- R3: `done_o` rises exactly 25 clock cycles (9 table-building additions plus one per multiplier digit) after the edge that accepts `start_i`; `busy_o` is high in between and low when `done_o` is high.
- R4: `done_o` is high for exactly one cycle per multiplication.
- R5: `sign_o` equals `x_sign_i` XOR `y_sign_i` as sampled at the accepting edge, and is held until the next accepted start.
- R6: `exp_o` equals `x_exp_i + y_exp_i` as 10-bit two's complement values sampled at the accepting edge, wrapping modulo 2^10.
- R7: A `start_i` pulse while `busy_o` is high is ignored: the running result, its operands and its completion cycle are unchanged.
- R8: The largest operands (all sixteen digits 9) yield the full 32-digit product with no lost digit.
- R9: While idle and with `start_i` low, `prod_o`, `sign_o` and `exp_o` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a multiplication; taken only when idle |
| x_i | input | 64 | Multiplicand coefficient, 16 packed BCD digits |
| y_i | input | 64 | Multiplier coefficient, 16 packed BCD digits |
| x_sign_i | input | 1 | Multiplicand sign (1 = negative) |
| y_sign_i | input | 1 | Multiplier sign (1 = negative) |
| x_exp_i | input | 10 | Multiplicand exponent, two's complement |
| y_exp_i | input | 10 | Multiplier exponent, two's complement |
| busy_o | output | 1 | High while a multiplication runs |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| prod_o | output | 128 | Product coefficient, 32 packed BCD digits |
| sign_o | output | 1 | Result sign |
| exp_o | output | 10 | Preliminary result exponent, two's complement |

## Verification
The assertions take for granted that `x_i` and `y_i` carry valid BCD digits (no nibble above 9) at the accepting edge, since the digit-validity check on the product is only meaningful for legal operands, and that the operand sign and exponent inputs are stable across that edge. Every stimulus vector, including the ones driven during a busy run to probe the ignored start, is written as legal BCD, and inputs only change half a cycle away from the sampling edge.

// File: rtl/bcdmul_pkg.sv
package bcdmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUILD = 2'd1,
    ST_ACCUM = 2'd2
  } mul_state_e;

  // Multiples 1..9 are stored; 0 is implicit
  localparam int unsigned NUM_MULT = 9;

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       c_o
);

  logic [4:0] raw;
  logic [4:0] adj;

  always_comb begin
    raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, c_i};
    adj = raw + 5'd6;
    c_o = (raw > 5'd9);
    s_o = c_o ? adj[3:0] : raw[3:0];
  end

endmodule

// File: rtl/bcd_adder.sv
module bcd_adder #(
  parameter int unsigned DIGITS = 32
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  output logic [4*DIGITS-1:0] sum_o
);

  logic [DIGITS:0] carry;

  assign carry[0] = 1'b0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_add u_dig (
      .a_i (a_i[4*d +: 4]),
      .b_i (b_i[4*d +: 4]),
      .c_i (carry[d]),
      .s_o (sum_o[4*d +: 4]),
      .c_o (carry[d+1])
    );
  end

endmodule

// File: rtl/bcd_mult_table.sv
module bcd_mult_table #(
  parameter int unsigned MW = 68
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    waddr_i,
  input  logic [MW-1:0] wdata_i,
  input  logic [3:0]    raddr_i,
  output logic [MW-1:0] rdata_o
);

  import bcdmul_pkg::*;

  logic [MW-1:0] entry_q [1:NUM_MULT];

  for (genvar k = 1; k <= NUM_MULT; k++) begin : g_entry
    logic hit;
    assign hit = we_i && (waddr_i == 4'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[k] <= '0;
      end else if (hit) begin
        entry_q[k] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 1; k <= NUM_MULT; k++) begin
      if (raddr_i == 4'(k)) rdata_o = entry_q[k];
    end
  end

endmodule

// File: rtl/bcd_coef_mul.sv
module bcd_coef_mul #(
  parameter int unsigned DIGITS = 16,
  parameter int unsigned EXP_W  = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [4*DIGITS-1:0]   x_i,
  input  logic [4*DIGITS-1:0]   y_i,
  input  logic                  x_sign_i,
  input  logic                  y_sign_i,
  input  logic [EXP_W-1:0]      x_exp_i,
  input  logic [EXP_W-1:0]      y_exp_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [8*DIGITS-1:0]   prod_o,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o
);

  import bcdmul_pkg::*;

  localparam int unsigned W      = 4 * DIGITS;
  localparam int unsigned PW     = 8 * DIGITS;
  localparam int unsigned MW     = 4 * (DIGITS + 1);
  localparam int unsigned STEP_W = $clog2(DIGITS + NUM_MULT);
  localparam logic [STEP_W-1:0] BUILD_LAST = STEP_W'(NUM_MULT - 1);
  localparam logic [STEP_W-1:0] ACCUM_LAST = STEP_W'(DIGITS - 1);

  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q  <= 1'b0;
      rst_sync_nq <= 1'b0;
    end else begin
      rst_meta_q  <= 1'b1;
      rst_sync_nq <= rst_meta_q;
    end
  end

  mul_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q,  step_d;
  logic [W-1:0]      x_q,     x_d;
  logic [W-1:0]      y_q,     y_d;
  logic [PW-1:0]     acc_q,   acc_d;
  logic              sign_q,  sign_d;
  logic [EXP_W-1:0]  exp_q,   exp_d;
  logic              done_q,  done_d;

  logic              tbl_we;
  logic [3:0]        tbl_waddr;
  logic [3:0]        tbl_raddr;
  logic [MW-1:0]     tbl_rdata;
  logic [PW-1:0]     add_a, add_b, add_sum;

  bcd_mult_table #(.MW(MW)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_nq),
    .we_i    (tbl_we),
    .waddr_i (tbl_waddr),
    .wdata_i (add_sum[MW-1:0]),
    .raddr_i (tbl_raddr),
    .rdata_o (tbl_rdata)
  );

  // One adder shared by both phases
  always_comb begin
    if (state_q == ST_BUILD) begin
      add_a = PW'(tbl_rdata);
      add_b = PW'(x_q);
    end else begin
      add_a = {acc_q[PW-5:0], 4'b0000};
      add_b = PW'(tbl_rdata);
    end
  end

  bcd_adder #(.DIGITS(2 * DIGITS)) u_adder (
    .a_i   (add_a),
    .b_i   (add_b),
    .sum_o (add_sum)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    x_d       = x_q;
    y_d       = y_q;
    acc_d     = acc_q;
    sign_d    = sign_q;
    exp_d     = exp_q;
    done_d    = 1'b0;
    tbl_we    = 1'b0;
    tbl_waddr = 4'd0;
    tbl_raddr = 4'd0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_BUILD;
          step_d  = '0;
          x_d     = x_i;
          y_d     = y_i;
          acc_d   = '0;
          sign_d  = x_sign_i ^ y_sign_i;
          exp_d   = x_exp_i + y_exp_i;
        end
      end
      ST_BUILD: begin
        tbl_raddr = step_q[3:0];
        tbl_waddr = step_q[3:0] + 4'd1;
        tbl_we    = 1'b1;
        if (step_q == BUILD_LAST) begin
          state_d = ST_ACCUM;
          step_d  = '0;
        end else begin
          step_d  = step_q + 1'b1;
        end
      end
      ST_ACCUM: begin
        tbl_raddr = y_q[W-1 -: 4];
        acc_d     = add_sum;
        y_d       = {y_q[W-5:0], 4'b0000};
        if (step_q == ACCUM_LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          step_d  = step_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_sync_nq) begin
    if (!rst_sync_nq) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      x_q     <= '0;
      y_q     <= '0;
      acc_q   <= '0;
      sign_q  <= 1'b0;
      exp_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      x_q     <= x_d;
      y_q     <= y_d;
      acc_q   <= acc_d;
      sign_q  <= sign_d;
      exp_q   <= exp_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign prod_o = acc_q;
  assign sign_o = sign_q;
  assign exp_o  = exp_q;

endmodule

// File: rtl/bcd_coef_mul_chk.sv
module bcd_coef_mul_chk #(
  parameter int unsigned DIGITS = 16,
  parameter int unsigned EXP_W  = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                x_sign_i,
  input logic                y_sign_i,
  input logic [EXP_W-1:0]    x_exp_i,
  input logic [EXP_W-1:0]    y_exp_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [8*DIGITS-1:0] prod_o,
  input logic                sign_o,
  input logic [EXP_W-1:0]    exp_o
);

  localparam int unsigned LAT   = DIGITS + 9;
  localparam int unsigned CNT_W = $clog2(LAT + 2);

  logic [CNT_W-1:0] lat_cnt;
  logic [EXP_W-1:0] exp_sum;

  assign exp_sum = x_exp_i + y_exp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_cnt <= '0;
    else if (!busy_o) lat_cnt <= '0;
    else              lat_cnt <= lat_cnt + 1'b1;
  end

  function automatic logic all_bcd(input logic [8*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < 2 * DIGITS; d++) begin
      if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R3
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt == CNT_W'(LAT)));

  // R5
  sign_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (sign_o == $past(x_sign_i ^ y_sign_i)));

  // R6
  exp_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (exp_o == $past(exp_sum)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(prod_o) && $stable(sign_o) && $stable(exp_o)));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !$rose(busy_o)) |=> (busy_o || done_o));

  // R2
  digit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> all_bcd(prod_o));

endmodule

bind bcd_coef_mul bcd_coef_mul_chk #(.DIGITS(DIGITS), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/bcd_coef_mul_tb.sv
module bcd_coef_mul_tb;

  localparam int CLK_P = 10;
  localparam int DIG   = 16;
  localparam int W     = 4 * DIG;
  localparam int PW    = 8 * DIG;
  localparam int EW    = 10;
  localparam int LAT   = DIG + 9;
  localparam int NV    = 6;

  localparam logic [W-1:0] VX [NV] = '{
    64'h0, 64'h1, 64'h9999999999999999,
    64'h12345678, 64'h5000000000000000, 64'h7};
  localparam logic [W-1:0] VY [NV] = '{
    64'h1234, 64'h9876543210987654, 64'h9999999999999999,
    64'h87654321, 64'h2, 64'h9999999999999999};
  localparam logic VSX [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic VSY [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [EW-1:0] VEX [NV] = '{
    10'sd5, -10'sd3, 10'sd300, -10'sd512, 10'sd0, 10'sd511};
  localparam logic [EW-1:0] VEY [NV] = '{
    10'sd7, 10'sd3, 10'sd300, -10'sd1, 10'sd0, 10'sd1};

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic [W-1:0]  x_i, y_i;
  logic          x_sign_i, y_sign_i;
  logic [EW-1:0] x_exp_i, y_exp_i;
  logic          busy_o, done_o, sign_o;
  logic [PW-1:0] prod_o;
  logic [EW-1:0] exp_o;

  int n_chk = 0;
  int n_bad = 0;

  bcd_coef_mul #(.DIGITS(DIG), .EXP_W(EW)) u_dut (
    .clk_i, .rst_ni, .start_i, .x_i, .y_i, .x_sign_i, .y_sign_i,
    .x_exp_i, .y_exp_i, .busy_o, .done_o, .prod_o, .sign_o, .exp_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    int col [2*DIG];
    logic [PW-1:0] r;
    int carry;
    for (int i = 0; i < 2*DIG; i++) col[i] = 0;
    for (int i = 0; i < DIG; i++)
      for (int j = 0; j < DIG; j++)
        col[i+j] += int'(a[4*i +: 4]) * int'(b[4*j +: 4]);
    carry = 0;
    r = '0;
    for (int i = 0; i < 2*DIG; i++) begin
      int t;
      t = col[i] + carry;
      r[4*i +: 4] = 4'(t % 10);
      carry = t / 10;
    end
    return r;
  endfunction

  task automatic launch(input logic [W-1:0] x, input logic [W-1:0] y, input logic sx,
                        input logic sy, input logic [EW-1:0] ex, input logic [EW-1:0] ey);
    @(negedge clk_i);
    x_i = x; y_i = y; x_sign_i = sx; y_sign_i = sy; x_exp_i = ex; y_exp_i = ey;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 200) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int cyc;
    rst_ni = 1'b0; start_i = 1'b0;
    x_i = '0; y_i = '0; x_sign_i = 1'b0; y_sign_i = 1'b0; x_exp_i = '0; y_exp_i = '0;
    repeat (3) @(negedge clk_i);
    // R1: state during reset
    check("R1 busy in reset", PW'(busy_o), '0);
    check("R1 prod in reset", prod_o, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1: state after release
    check("R1 done after reset", PW'(done_o), '0);
    check("R1 busy after reset", PW'(busy_o), '0);

    // Vector table: R2 R3 R4 R5 R6 (R8 = entry 2)
    for (int v = 0; v < NV; v++) begin
      launch(VX[v], VY[v], VSX[v], VSY[v], VEX[v], VEY[v]);
      check("R3 busy after start", PW'(busy_o), PW'(1));
      wait_done(cyc);
      check("R3 latency", PW'(cyc), PW'(LAT));
      check((v == 2) ? "R8 full width product" : "R2 product", prod_o, ref_mul(VX[v], VY[v]));
      check("R5 sign", PW'(sign_o), PW'(VSX[v] ^ VSY[v]));
      check("R6 exponent", PW'(exp_o), PW'(EW'(VEX[v] + VEY[v])));
      @(negedge clk_i);
      check("R4 done one cycle", PW'(done_o), '0);
    end

    // R7: start during busy is ignored
    launch(64'h25, 64'h4, 1'b0, 1'b1, 10'sd2, 10'sd3);
    repeat (2) @(negedge clk_i);
    x_i = 64'h9999; y_i = 64'h88; x_sign_i = 1'b1; x_exp_i = 10'sd100;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(cyc);
    check("R7 latency unchanged", PW'(cyc + 3), PW'(LAT));
    check("R7 product unchanged", prod_o, PW'(128'h100));
    check("R7 sign unchanged", PW'(sign_o), PW'(1));
    check("R7 exponent unchanged", PW'(exp_o), PW'(5));

    // R9: idle outputs hold while inputs change without start
    x_i = 64'h31; y_i = 64'h77; x_sign_i = 1'b0; y_sign_i = 1'b0; x_exp_i = 10'sd9;
    repeat (5) @(negedge clk_i);
    check("R9 product held", prod_o, PW'(128'h100));
    check("R9 sign held", PW'(sign_o), PW'(1));
    check("R9 exponent held", PW'(exp_o), PW'(5));
    check("R9 stays idle", PW'(busy_o), '0);

    // R1: reset aborts a running multiplication
    launch(64'h123, 64'h456, 1'b0, 1'b0, 10'sd1, 10'sd1);
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 abort busy", PW'(busy_o), '0);
    check("R1 abort prod", prod_o, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    launch(64'h123, 64'h456, 1'b0, 1'b0, 10'sd1, 10'sd1);
    wait_done(cyc);
    check("R2 product after abort", prod_o, PW'(128'h56088));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule